// File: doc/BRIEF.md
# Dual-Mode Frame-Sync Serial Port

This block is the converter-side serial port of a two-channel voice/data codec. Each channel has its own serial clock, frame sync, serial data out and serial data in. The block derives the serial clock from the system clock and repeats a fixed frame without stopping. In every frame it shifts out one 16-bit word taken from a parallel input. In the same bit slots it shifts in one 16-bit word, which it presents on a parallel output together with a one-cycle valid strobe.

A static mode pin selects one of two frame-sync styles, and both channels follow it. In pulse style, frame sync is high for one serial-clock period just before the first data bit. In envelope style, frame sync is low across all sixteen data bits and is high outside them. Both styles use the same slot layout and the same full-duplex shifter, so only the frame-sync level depends on the mode.

Top module: `fsp_port`

## Requirements
- R1: While `rst` is high, each channel holds `sclk_o` at 0, `sd_out_o` at 0, `rx_valid_o` at 0 and its `rx_word_o` slice at 0. Each `fs_o` sits at the idle level of the current `mode_i`: 0 when `mode_i`=1 and 1 when `mode_i`=0.
- R2: Each `sclk_o` has a period of 2*HALF_DIV system clocks, with HALF_DIV clocks high and HALF_DIV clocks low.
- R3: A frame lasts FRAME_SLOTS serial-clock periods, and slots run from one rising edge of `sclk_o` to the next. Slot 0 begins at the first rising edge after reset, and frames follow one another with no gap. Slots 1 to 16 carry data. The rest are idle.
- R4: With `mode_i`=1 (pulse style), `fs_o` is high for slot 0 only and low in every other slot.
- R5: With `mode_i`=0 (envelope style), `fs_o` falls at the start of slot 1. It stays low through slot 16 and is high in slot 0 and in slots 17 and above.
- R6: `sd_out_o` carries the transmit word most significant bit first: bit 15 in slot 1 and bit 0 in slot 16. It changes only at rising edges of `sclk_o` and is 0 in all other slots.
- R7: `sd_in_i` is sampled on the falling edge of `sclk_o` in slots 1 to 16. The bit taken in slot 1 becomes bit 15 of the received word and the bit taken in slot 16 becomes bit 0.
- R8: `rx_valid_o` is high for exactly one system clock, the cycle after the bit-0 sample is taken. The new word appears on `rx_word_o` in that same cycle and stays unchanged until the next valid strobe.
- R9: The `tx_word_i` value present at the rising edge that opens slot 0 is the word sent in that frame. Changes to `tx_word_i` later in the frame do not alter the bits on `sd_out_o`.
- R10: `mode_i` is taken only at the start of slot 0. A change made in the middle of a frame leaves that frame's frame-sync pattern unchanged.
- R11: Channel c uses bits [16c+15:16c] of `tx_word_i` and `rx_word_o` and bit c of each serial pin. Channels do not affect one another's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Frame-sync style: 1 pulse, 0 envelope |
| tx_word_i | input | NUM_CH*WORD_W | Words to transmit, one slice per channel |
| rx_word_o | output | NUM_CH*WORD_W | Last received word of each channel |
| rx_valid_o | output | NUM_CH | One-cycle strobe per channel when a received word is complete |
| sclk_o | output | NUM_CH | Serial clock of each channel |
| fs_o | output | NUM_CH | Frame sync of each channel |
| sd_out_o | output | NUM_CH | Serial data out of each channel |
| sd_in_i | input | NUM_CH | Serial data in of each channel |

## Verification
A slot counter that drifts, or a mode latch taken at the wrong time, moves the `fs_o` edges. A mismatch between the pin and the expected frame-sync level then shows up within one serial-clock period. A shifter that loads late or shifts on the wrong edge puts a wrong bit on `sd_out_o` in the first affected data slot. A receive path that samples on the wrong edge, or assembles bits in the wrong order, gives a wrong `rx_word_o` at the strobe one system clock after slot 16. Single-bit walking patterns and mid-frame changes to the transmit word and to the mode pin expose each of these faults in the frame where they occur.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic {
    FS_ENVELOPE = 1'b0,
    FS_PULSE    = 1'b1
  } fs_mode_e;

  function automatic logic idle_level(input fs_mode_e m);
    return (m == FS_PULSE) ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/fsp_sclk_gen.sv
module fsp_sclk_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sclk_q;
  logic             wrap;

  assign wrap   = (cnt_q == CNT_LAST);
  assign rise_o = wrap && !sclk_q;
  assign fall_o = wrap && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LAST); // R2
  AST_RISE_HIGH: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> sclk_o); // R2
  AST_FALL_LOW: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !sclk_o); // R2

endmodule

// File: rtl/fsp_framer.sv
module fsp_framer
  import fsp_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int FRAME_SLOTS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_i,
  input  logic              sclk_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              sd_in_i,
  output logic              fs_o,
  output logic              sd_out_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o
);

  localparam int SLOT_W = $clog2(FRAME_SLOTS);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FRAME_SLOTS - 1);
  localparam logic [SLOT_W-1:0] DATA_FIRST = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] DATA_LAST = SLOT_W'(WORD_W);

  logic [SLOT_W-1:0] slot_q, slot_nx;
  fs_mode_e          mode_q, mode_nx, mode_pin;
  logic              data_nx, data_cur;
  logic [WORD_W-1:0] tx_sh, rx_sh, rx_next;
  logic              fs_q, dout_q;

  assign mode_pin = fs_mode_e'(mode_i);
  assign slot_nx  = (slot_q == SLOT_LAST) ? '0 : slot_q + SLOT_W'(1);
  assign mode_nx  = (slot_nx == '0) ? mode_pin : mode_q;
  assign data_nx  = (slot_nx >= DATA_FIRST) && (slot_nx <= DATA_LAST);
  assign data_cur = (slot_q >= DATA_FIRST) && (slot_q <= DATA_LAST);
  assign rx_next  = {rx_sh[WORD_W-2:0], sd_in_i};

  // Transmit side: everything moves on the serial-clock rising edge
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= SLOT_LAST;
      mode_q <= mode_pin;
      fs_q   <= idle_level(mode_pin);
      dout_q <= 1'b0;
      tx_sh  <= '0;
    end else if (rise_i) begin
      slot_q <= slot_nx;
      mode_q <= mode_nx;
      if (mode_nx == FS_PULSE) fs_q <= (slot_nx == '0);
      else                     fs_q <= !data_nx;
      if (slot_nx == '0) begin
        tx_sh  <= tx_word_i;
        dout_q <= 1'b0;
      end else if (data_nx) begin
        dout_q <= tx_sh[WORD_W-1];
        tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
      end else begin
        dout_q <= 1'b0;
      end
    end
  end

  // Receive side: samples on the serial-clock falling edge
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh      <= '0;
      rx_word_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (fall_i && data_cur) begin
        rx_sh <= rx_next;
        if (slot_q == DATA_LAST) begin
          rx_word_o  <= rx_next;
          rx_valid_o <= 1'b1;
        end
      end
    end
  end

  assign fs_o     = fs_q;
  assign sd_out_o = dout_q;

  AST_FS_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !$stable(fs_o) |-> $rose(sclk_i)); // R4
  AST_PULSE_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
    (rise_i && fs_o && mode_q == FS_PULSE) |=> !fs_o); // R4
  AST_DOUT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_out_o) |-> $rose(sclk_i)); // R6
  AST_RX_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_sh) |-> $fell(sclk_i)); // R7
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o); // R8
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_word_o) |-> rx_valid_o); // R8
  AST_MODE_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> (slot_q == '0)); // R10
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot_q <= SLOT_LAST); // R3

endmodule

// File: rtl/fsp_port.sv
module fsp_port #(
  parameter int NUM_CH      = 2,
  parameter int WORD_W      = 16,
  parameter int FRAME_SLOTS = 20,
  parameter int HALF_DIV    = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mode_i,
  input  logic [NUM_CH*WORD_W-1:0] tx_word_i,
  output logic [NUM_CH*WORD_W-1:0] rx_word_o,
  output logic [NUM_CH-1:0]        rx_valid_o,
  output logic [NUM_CH-1:0]        sclk_o,
  output logic [NUM_CH-1:0]        fs_o,
  output logic [NUM_CH-1:0]        sd_out_o,
  input  logic [NUM_CH-1:0]        sd_in_i
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sclk, rise, fall;

    fsp_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
      .clk    (clk),
      .rst    (rst),
      .sclk_o (sclk),
      .rise_o (rise),
      .fall_o (fall)
    );

    fsp_framer #(.WORD_W(WORD_W), .FRAME_SLOTS(FRAME_SLOTS)) u_frm (
      .clk        (clk),
      .rst        (rst),
      .mode_i     (mode_i),
      .sclk_i     (sclk),
      .rise_i     (rise),
      .fall_i     (fall),
      .tx_word_i  (tx_word_i[c*WORD_W +: WORD_W]),
      .sd_in_i    (sd_in_i[c]),
      .fs_o       (fs_o[c]),
      .sd_out_o   (sd_out_o[c]),
      .rx_word_o  (rx_word_o[c*WORD_W +: WORD_W]),
      .rx_valid_o (rx_valid_o[c])
    );

    assign sclk_o[c] = sclk;
  end

endmodule

// File: tb/fsp_port_tb.sv
module fsp_port_tb;

  localparam int NCH = 2;
  localparam int W = 16;
  localparam int SLOTS = 18;
  localparam int HALF = 2;
  localparam int FRAMES = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b1;
  logic [NCH*W-1:0] tx_word = '0;
  logic [NCH*W-1:0] rx_word;
  logic [NCH-1:0] rx_valid, sclk, fs, sd_out;
  logic [NCH-1:0] sd_in = '0;

  int n_chk = 0, n_fail = 0, cyc = 0, rst_cyc = 0;
  int slot [NCH];
  int since [NCH];
  int frame [NCH];
  logic prev_s [NCH];
  logic exp_mode [NCH];
  logic [W-1:0] exp_tx [NCH];
  logic [W-1:0] rx_pat [NCH];
  logic [W-1:0] last_rx [NCH];

  fsp_port #(.NUM_CH(NCH), .WORD_W(W), .FRAME_SLOTS(SLOTS), .HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst(rst), .mode_i(mode), .tx_word_i(tx_word), .rx_word_o(rx_word),
    .rx_valid_o(rx_valid), .sclk_o(sclk), .fs_o(fs), .sd_out_o(sd_out), .sd_in_i(sd_in)
  );

  always #10 clk = ~clk;

  function automatic logic [W-1:0] tx_fn(input int f, input int c);
    if (f == 0) return (c == 0) ? 16'hFFFF : 16'h0000;
    if (f == 1) return (c == 0) ? 16'h0000 : 16'hFFFF;
    if (f >= 2 && f <= 17) return (c == 0) ? (16'h0001 << (f - 2)) : (16'h8000 >> (f - 2));
    return W'(f * 16'h3B1D) ^ ((c == 0) ? 16'h0000 : 16'hC35A);
  endfunction

  function automatic logic [W-1:0] rx_fn(input int f, input int c);
    return ~tx_fn(f + 3, 1 - c);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      slot[c] = -1; since[c] = -1; frame[c] = -1; prev_s[c] = 1'b0;
      exp_mode[c] = 1'b0; exp_tx[c] = '0; rx_pat[c] = '0; last_rx[c] = '0;
    end
    repeat (8) @(negedge clk);
    #1 rst = 1'b0;
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      chk(1'b0, "watchdog", 32'(cyc), 32'd20000);
      finish_run();
    end
    if (rst) begin
      // R1: reset state, idle frame-sync level follows the mode pin
      if (rst_cyc == 2 || rst_cyc == 7) begin
        chk(fs == ((rst_cyc == 2) ? 2'b00 : 2'b11), "R1 fs idle", 32'(fs), 32'((rst_cyc == 2) ? 0 : 3));
        chk(sclk == '0 && sd_out == '0 && rx_valid == '0, "R1 pins", 32'({sclk, sd_out, rx_valid}), 32'd0);
        chk(rx_word == '0, "R1 rx_word", rx_word, 32'd0);
      end
      mode = (rst_cyc < 3) ? 1'b1 : 1'b0;
      for (int c = 0; c < NCH; c++) tx_word[c*W +: W] = tx_fn(0, c);
      rst_cyc++;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        logic s_now, rose, fell, efs, edo;
        s_now = sclk[c];
        rose = s_now && !prev_s[c];
        fell = !s_now && prev_s[c];
        prev_s[c] = s_now;
        if (rose) begin
          if (since[c] >= 0) chk(since[c] == 2 * HALF - 1, "R2 period", 32'(since[c] + 1), 32'(2 * HALF));
          since[c] = 0;
          slot[c] = (slot[c] < 0 || slot[c] == SLOTS - 1) ? 0 : slot[c] + 1;
          if (slot[c] == 0) begin
            frame[c]++;
            exp_mode[c] = mode;                 // R10: taken at frame start
            exp_tx[c] = tx_word[c*W +: W];      // R9: taken at frame start
            rx_pat[c] = rx_fn(frame[c], c);
          end
        end else if (since[c] >= 0) begin
          since[c]++;
        end
        if (fell) chk(since[c] == HALF, "R2 duty", 32'(since[c]), 32'(HALF));
        // expected frame sync and data for the current slot
        if (slot[c] < 0) begin
          efs = !mode; edo = 1'b0;
        end else begin
          if (exp_mode[c]) efs = (slot[c] == 0);
          else efs = !(slot[c] >= 1 && slot[c] <= W);
          edo = (slot[c] >= 1 && slot[c] <= W) ? exp_tx[c][W - slot[c]] : 1'b0;
        end
        chk(fs[c] == efs, exp_mode[c] ? "R4 fs pulse" : "R5 fs envelope", 32'(fs[c]), 32'(efs));
        chk(sd_out[c] == edo, "R6 R9 R11 sd_out", 32'(sd_out[c]), 32'(edo));
        if (fell && slot[c] == W) begin
          chk(rx_valid[c] == 1'b1, "R8 valid", 32'(rx_valid[c]), 32'd1);
          chk(rx_word[c*W +: W] == rx_pat[c], "R7 R11 rx_word", 32'(rx_word[c*W +: W]), 32'(rx_pat[c]));
          last_rx[c] = rx_pat[c];
        end else begin
          chk(rx_valid[c] == 1'b0, "R8 valid low", 32'(rx_valid[c]), 32'd0);
          chk(rx_word[c*W +: W] == last_rx[c], "R8 held", 32'(rx_word[c*W +: W]), 32'(last_rx[c]));
        end
        // drive stimulus for the next edges
        if (rose) begin
          sd_in[c] = (slot[c] >= 1 && slot[c] <= W) ? rx_pat[c][W - slot[c]] : 1'b0;
          if (slot[c] == 5) tx_word[c*W +: W] = ~exp_tx[c] ^ 16'h0F0F;   // R9 disturbance
          if (slot[c] == SLOTS - 1) tx_word[c*W +: W] = tx_fn(frame[c] + 1, c);
          if (c == 0 && slot[c] == 8 && (frame[c] % 3) == 2) mode = ~mode; // R10 mid-frame change
        end
      end
      if (frame[0] == FRAMES) finish_run();
    end
  end

endmodule